// File: doc/BRIEF.md
# Byte-Stream Serial Register Port on an I/O Bus

This block is the processor-facing register front end of a simple asynchronous serial channel. It sits on an I/O-mapped bus that uses active-low request, read and write strobes and the low address byte. It presents a control register, a status register, a receive byte and a transmit byte through two port addresses. The serial side is not bit-level. Received bytes come in as a stream with valid/ready, and bytes written by the processor leave as a stream with a valid/ready handshake. The block keeps the register state, decides which bus cycle causes side effects, and drives an active-low interrupt.

Two state machines do the work. The bus sequencer has the states BUS_IDLE, BUS_READ, BUS_WRITE and BUS_SKIP.
- BUS_IDLE goes to BUS_READ on a request with read low at a mapped address.
- BUS_IDLE goes to BUS_WRITE on a request with write low at a mapped address.
- BUS_IDLE goes to BUS_SKIP on any other request.
- Every non-idle state returns to BUS_IDLE when the request strobe goes high.
- Side effects happen only on the BUS_IDLE-to-busy edge, which is the first cycle of an access.

The transmit slot has the states TX_EMPTY and TX_PEND.
- A data-port write moves TX_EMPTY to TX_PEND.
- A completed handshake moves TX_PEND to TX_EMPTY, unless a new write lands in the same cycle.
- A write while in TX_PEND replaces the pending byte.

Control and status share one address. A read there returns status, and a write there loads control. The receive-full flag and the interrupt are both gated by a ready-to-send bit held in control.

Top module: `acia_bus_port`

## Requirements
- R1: After a synchronous reset, a status read returns 0x02, a data-port read with no byte waiting returns 0x00, `int_n` is 1, `dout_en` is 0 and `tx_valid` is 0.
- R2: Address 0x81 is the data port. At address 0x80, a read returns status and a write loads control.
- R3: The control field positions are fixed. Bit 7 enables the receive interrupt. Bit 6 is the ready-to-send (RTS) state. Bit 5 is the transmit-interrupt enable, which has no effect here. Reset loads RTS = 1 and receive interrupt = 0.
- R4: Status layout: bit 0 is receive-full, bit 1 is transmit-empty, and bits 7..2 read 0. Receive-full is 1 in a cycle only if, in the previous cycle, RTS was 0 and `rx_valid` was 1. Otherwise it is 0.
- R5: `int_n` is 0 in a cycle only if, in the previous cycle, RTS was 0, `rx_valid` was 1 and the receive-interrupt enable was 1. Otherwise it is 1.
- R6: A data-port read whose first cycle sees `rx_valid` = 1 raises `rx_ready` in that cycle. The block stores the byte in the receive register and drives it on `dout`. If no byte is waiting, the stored receive byte is driven and nothing is consumed.
- R7: A data-port write stores `din` as the pending transmit byte. It raises `tx_valid` from the next cycle and clears transmit-empty. Transmit-empty returns to 1 once the byte is taken by `tx_valid` and `tx_ready` both high.
- R8: Side effects occur only in the first cycle of a request, after the request strobe was high. While a read continues, `dout` holds the latched byte and no further byte is consumed.
- R9: When no read of a mapped address is in progress, including during writes, `dout` is 0 and `dout_en` is 0.
- R10: Accesses at any address other than 0x80 and 0x81 change no register and never drive the bus.
- R11: While `tx_ready` is 0, `tx_valid` stays 1 and transmit-empty stays 0. A write in that state replaces the pending byte, and only the latest byte is handed off.
- R12: Holding `rst_n` low for one clock edge forces `int_n` to 1 and `dout_en` to 0 and restores the reset register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iorq_n | input | 1 | Active-low I/O request strobe |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 8 | Low address byte |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data |
| dout_en | output | 1 | Read-data drive enable |
| int_n | output | 1 | Active-low interrupt |
| rx_data | input | 8 | Received byte from the stream |
| rx_valid | input | 1 | A received byte is waiting |
| rx_ready | output | 1 | Consume the waiting byte this cycle |
| tx_data | output | 8 | Byte to transmit |
| tx_valid | output | 1 | Transmit byte pending |
| tx_ready | input | 1 | Transmit stream accepts the byte |

## Verification
Read data reaches `dout` and `dout_en` one edge after the first request cycle. `rx_ready` is combinational within that first cycle. Receive-full and `int_n` follow their inputs by one edge, so a control write counts from the edge that stores it and its flags are due one edge later. `tx_valid` rises one edge after the write, and transmit-empty returns one edge after the handshake. The bench drives every input on the falling edge and samples on the next falling edge, at least one full rising edge after each of these points. Status is always read through a fresh bus access, which starts after the previous access has been released for one idle cycle.

// File: rtl/acia_pkg.sv
package acia_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_READ,
        BUS_WRITE,
        BUS_SKIP
    } bus_state_t;

    typedef enum logic {
        TX_EMPTY,
        TX_PEND
    } tx_state_t;

    // status bit positions
    localparam int STAT_RXF = 0;
    localparam int STAT_TXE = 1;

    // control bit positions
    localparam int CTRL_RXIE = 7;
    localparam int CTRL_RTS  = 6;

endpackage

// File: rtl/acia_bus_fsm.sv
module acia_bus_fsm
    import acia_pkg::*;
#(
    parameter int              AW        = 8,
    parameter logic [AW-1:0]   DATA_PORT = 'h81,
    parameter logic [AW-1:0]   CTRL_PORT = 'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iorq_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    output logic          rd_data_go,
    output logic          rd_stat_go,
    output logic          wr_data_go,
    output logic          wr_ctrl_go,
    output logic          rd_hold
);

    bus_state_t state_q, state_d;
    logic hit_data, hit_ctrl, hit_any, first;

    assign hit_data = (addr == DATA_PORT);
    assign hit_ctrl = (addr == CTRL_PORT);
    assign hit_any  = hit_data | hit_ctrl;
    assign first    = (state_q == BUS_IDLE) && !iorq_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (!iorq_n) begin
                    if (!rd_n && hit_any)      state_d = BUS_READ;
                    else if (!wr_n && hit_any) state_d = BUS_WRITE;
                    else                       state_d = BUS_SKIP;
                end
            end
            BUS_READ, BUS_WRITE, BUS_SKIP: begin
                if (iorq_n) state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        rd_data_go = first && !rd_n && hit_data;
        rd_stat_go = first && !rd_n && hit_ctrl;
        wr_data_go = first && rd_n && !wr_n && hit_data;
        wr_ctrl_go = first && rd_n && !wr_n && hit_ctrl;
        rd_hold    = (state_q == BUS_READ) && !iorq_n && !rd_n && hit_any;
    end

endmodule

// File: rtl/acia_tx_slot.sv
module acia_tx_slot
    import acia_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic          empty
);

    tx_state_t state_q, state_d;
    logic [DW-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_EMPTY: if (load) state_d = TX_PEND;
            TX_PEND:  if (tx_ready && !load) state_d = TX_EMPTY;
            default:  state_d = TX_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    byte_q <= '0;
        else if (load) byte_q <= load_data;
    end

    always_comb begin
        tx_data  = byte_q;
        tx_valid = (state_q == TX_PEND);
        empty    = (state_q == TX_EMPTY);
    end

endmodule

// File: rtl/acia_bus_port.sv
module acia_bus_port
    import acia_pkg::*;
#(
    parameter int              AW        = 8,
    parameter int              DW        = 8,
    parameter logic [AW-1:0]   DATA_PORT = 'h81,
    parameter logic [AW-1:0]   CTRL_PORT = 'h80,
    parameter logic [DW-1:0]   CTRL_INIT = 'h54
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iorq_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          int_n,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_valid,
    output logic          rx_ready,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_ready
);

    logic rd_data_go, rd_stat_go, wr_data_go, wr_ctrl_go, rd_hold;
    logic rxie_q, rts_q, rxf_q, int_n_q, txe;
    logic [DW-1:0] rx_q, dout_q, status;
    logic dout_en_q;

    acia_bus_fsm #(
        .AW        (AW),
        .DATA_PORT (DATA_PORT),
        .CTRL_PORT (CTRL_PORT)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .iorq_n     (iorq_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .rd_data_go (rd_data_go),
        .rd_stat_go (rd_stat_go),
        .wr_data_go (wr_data_go),
        .wr_ctrl_go (wr_ctrl_go),
        .rd_hold    (rd_hold)
    );

    acia_tx_slot #(.DW(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_data_go),
        .load_data (din),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .empty     (txe)
    );

    // control: only the bits with an effect in this block are kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxie_q <= CTRL_INIT[CTRL_RXIE];
            rts_q  <= CTRL_INIT[CTRL_RTS];
        end else if (wr_ctrl_go) begin
            rxie_q <= din[CTRL_RXIE];
            rts_q  <= din[CTRL_RTS];
        end
    end

    // receive-full flag and interrupt, re-evaluated every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxf_q   <= 1'b0;
            int_n_q <= 1'b1;
        end else begin
            rxf_q   <= !rts_q && rx_valid;
            int_n_q <= !(!rts_q && rx_valid && rxie_q);
        end
    end

    always_comb begin
        status           = '0;
        status[STAT_RXF] = rxf_q;
        status[STAT_TXE] = txe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      rx_q <= '0;
        else if (rd_data_go && rx_valid) rx_q <= rx_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q    <= '0;
            dout_en_q <= 1'b0;
        end else if (rd_data_go) begin
            dout_q    <= rx_valid ? rx_data : rx_q;
            dout_en_q <= 1'b1;
        end else if (rd_stat_go) begin
            dout_q    <= status;
            dout_en_q <= 1'b1;
        end else if (rd_hold) begin
            dout_en_q <= 1'b1;
        end else begin
            dout_q    <= '0;
            dout_en_q <= 1'b0;
        end
    end

    assign rx_ready = rd_data_go && rx_valid;
    assign dout     = dout_q;
    assign dout_en  = dout_en_q;
    assign int_n    = int_n_q;

endmodule

// File: rtl/acia_bus_port_chk.sv
module acia_bus_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       iorq_n,
    input logic       rd_n,
    input logic [7:0] addr,
    input logic [7:0] dout,
    input logic       dout_en,
    input logic       int_n,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rts,
    input logic       rxf
);

    a_r4_rxf_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (rts || !rx_valid) |=> !rxf);

    a_r5_int_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rts |=> int_n);

    a_r6_consume_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (rx_valid && !iorq_n && !rd_n && addr == 8'h81));

    a_r8_single_consume: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |=> !rx_ready);

    a_r9_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (iorq_n || rd_n) |=> (!dout_en && dout == 8'h00));

    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && addr != 8'h80 && addr != 8'h81) |=> !dout_en);

    a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> tx_valid);

    a_r12_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> (int_n && !dout_en && !tx_valid));

endmodule

bind acia_bus_port acia_bus_port_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .iorq_n   (iorq_n),
    .rd_n     (rd_n),
    .addr     (addr),
    .dout     (dout),
    .dout_en  (dout_en),
    .int_n    (int_n),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rts      (rts_q),
    .rxf      (rxf_q)
);

// File: tb/acia_bus_port_test.sv
`timescale 1ns/1ps
module acia_bus_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] addr = 8'h00, din = 8'h00, rx_data = 8'h00;
    logic       rx_valid = 1'b0, tx_ready = 1'b1;
    logic [7:0] dout, tx_data;
    logic       dout_en, int_n, rx_ready, tx_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int sink_cnt = 0;
    logic [7:0] sink_last = 8'h00;

    always #2.5 clk = ~clk;

    acia_bus_port uut (
        .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .int_n(int_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    always @(posedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            sink_cnt  <= sink_cnt + 1;
            sink_last <= tx_data;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d,
                          output logic en, output logic took);
        @(negedge clk);
        addr = a; iorq_n = 1'b0; rd_n = 1'b0;
        #1 took = rx_ready;
        @(negedge clk);
        d = dout; en = dout_en;
        if (took) rx_valid = 1'b0;
        iorq_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] v, output logic en);
        @(negedge clk);
        addr = a; din = v; iorq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        en = dout_en;
        iorq_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    // {control value, rx_valid, expected receive-full, expected int_n}
    localparam logic [10:0] VEC [6] = '{
        {8'h00, 1'b1, 1'b1, 1'b1},
        {8'h80, 1'b1, 1'b1, 1'b0},
        {8'hC0, 1'b1, 1'b0, 1'b1},
        {8'h80, 1'b0, 1'b0, 1'b1},
        {8'h40, 1'b1, 1'b0, 1'b1},
        {8'hA0, 1'b1, 1'b1, 1'b0}
    };

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic en, took;
        int base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 int_n", {7'b0, int_n}, 8'h01);
        chk("R1 dout_en", {7'b0, dout_en}, 8'h00);
        chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        bus_rd(8'h80, d, en, took);
        chk("R1 R2 status", d, 8'h02);
        chk("R2 status drive", {7'b0, en}, 8'h01);
        bus_rd(8'h81, d, en, took);
        chk("R1 rx reset", d, 8'h00);
        chk("R6 no consume when empty", {7'b0, took}, 8'h00);

        // R3 R4 R5 vector walk
        for (int i = 0; i < 6; i++) begin
            rx_valid = VEC[i][2];
            bus_wr(8'h80, VEC[i][10:3], en);
            chk("R9 write no drive", {7'b0, en}, 8'h00);
            chk("R5 int_n", {7'b0, int_n}, {7'b0, VEC[i][0]});
            bus_rd(8'h80, d, en, took);
            chk("R4 receive-full", {7'b0, d[0]}, {7'b0, VEC[i][1]});
            chk("R3 R4 upper status", {d[7:2], 2'b00}, 8'h00);
        end
        rx_valid = 1'b0;
        bus_wr(8'h80, 8'h54, en);

        // R6 consume and R8 hold
        rx_data = 8'h5A; rx_valid = 1'b1;
        @(negedge clk);
        addr = 8'h81; iorq_n = 1'b0; rd_n = 1'b0;
        #1 chk("R6 rx_ready", {7'b0, rx_ready}, 8'h01);
        @(negedge clk);
        chk("R6 read byte", dout, 8'h5A);
        rx_valid = 1'b1; rx_data = 8'h33;
        for (int k = 0; k < 2; k++) begin
            #1 chk("R8 no second consume", {7'b0, rx_ready}, 8'h00);
            @(negedge clk);
            chk("R8 held byte", dout, 8'h5A);
            chk("R8 held drive", {7'b0, dout_en}, 8'h01);
        end
        iorq_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        chk("R9 released dout", dout, 8'h00);
        chk("R9 released en", {7'b0, dout_en}, 8'h00);
        bus_rd(8'h81, d, en, took);
        chk("R6 next byte", d, 8'h33);
        bus_rd(8'h81, d, en, took);
        chk("R6 empty keeps register", d, 8'h33);

        // R7 transmit
        base = sink_cnt;
        bus_wr(8'h81, 8'hA7, en);
        chk("R7 handed count", 8'(sink_cnt - base), 8'h01);
        chk("R7 handed byte", sink_last, 8'hA7);
        bus_rd(8'h80, d, en, took);
        chk("R7 txe restored", d, 8'h02);

        // R11 backpressure and overwrite
        tx_ready = 1'b0;
        base = sink_cnt;
        bus_wr(8'h81, 8'h11, en);
        chk("R11 tx_valid held", {7'b0, tx_valid}, 8'h01);
        bus_rd(8'h80, d, en, took);
        chk("R11 txe clear", d, 8'h00);
        bus_wr(8'h81, 8'h22, en);
        chk("R11 pending overwrite", tx_data, 8'h22);
        tx_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 one handoff", 8'(sink_cnt - base), 8'h01);
        chk("R11 latest byte", sink_last, 8'h22);
        bus_rd(8'h80, d, en, took);
        chk("R11 txe back", d, 8'h02);

        // R10 unmapped
        rx_valid = 1'b1; rx_data = 8'h44;
        base = sink_cnt;
        bus_wr(8'h82, 8'h00, en);
        bus_wr(8'h40, 8'h00, en);
        bus_rd(8'h80, d, en, took);
        chk("R10 control untouched", d, 8'h02);
        chk("R10 no transmit", 8'(sink_cnt - base), 8'h00);
        bus_rd(8'h40, d, en, took);
        chk("R10 no drive", {7'b0, en}, 8'h00);
        chk("R10 no consume", {7'b0, took}, 8'h00);

        // R12 reset mid-operation
        bus_wr(8'h80, 8'h80, en);
        chk("R5 int asserted", {7'b0, int_n}, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12 int_n high", {7'b0, int_n}, 8'h01);
        chk("R12 drive off", {7'b0, dout_en}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(8'h80, d, en, took);
        chk("R12 status after reset", d, 8'h02);
        chk("R12 int stays high", {7'b0, int_n}, 8'h01);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule